// File: doc/BRIEF.md
# Banked Prefetching Buffer Read Port

This block is the host-facing read path into a shared double-word buffer RAM. The host first loads the RAM through ordinary writes at byte addresses from 0400h upward. It then writes a single control register that names a start address and one of four banks. After that, every read tagged with that bank returns the next double word in sequence from a pointer held inside the block. The address presented with the read plays no part beyond marking the access as a buffer access.

Each bank has its own pointer, a holding register with the double word it will deliver next, and a half-word phase. Streams from different banks can therefore be interleaved freely. The fetch of the first word is launched by the setup write itself, so a read issued in the very next cycle already returns the programmed start word. A strap input selects a 16-bit host data path. In that mode each double word is delivered as two reads, low half first, and the pointer moves on only after the high half.

Top module: `bank_prefetch_rdport`

## Requirements
- R1: While reset is asserted and in the first cycle after release, `rvalid` is 0 and `rdata` is 0.
- R2: A write with `addr` >= 0400h stores all 32 bits of `wdata` in RAM word ((addr >> 2) - 100h) modulo the RAM depth. `addr[1:0]` is ignored, so every access is double-word aligned.
- R3: A write to the control address 033Ch loads the bank selected by `wdata[17:16]` with start word index ((wdata[15:2]) - 100h) modulo the depth. `wdata[1:0]` and `wdata[31:18]` are ignored. The first read of that bank returns the word at the start index, even when the read is issued in the cycle right after the setup write.
- R4: In 32-bit mode (`bus16` = 0), a read (`rd_en` with `wr_en` low and `addr` >= 0400h) is answered one cycle later with `rvalid` = 1 and the full double word. Successive reads of the same bank return successive words, whatever the value of `addr`. `rvalid` is 0 in any cycle that does not follow a read.
- R5: A read of one bank never moves the pointer, phase or held data of any other bank, so interleaved streams each stay in sequence.
- R6: A setup write reloads only the selected bank and clears only that bank's half phase.
- R7: In 16-bit mode (`bus16` = 1), reads of a bank alternate between returning bits [15:0] and then bits [31:16] of the current word, always in `rdata[15:0]`, with `rdata[31:16]` = 0. The pointer advances only after the high half.
- R8: A read with `addr` below 0400h returns `rvalid` = 1 with `rdata` = 0 and moves no pointer.
- R9: Reads issued in every cycle, including to the bank whose refill is still in flight, return the correct sequence with no gaps.
- R10: A bank pointer at the last RAM word wraps to word 0 on its next advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus16 | input | 1 | 1 selects the 16-bit host data path |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access; ignored while `wr_en` is high |
| addr | input | 16 | Host byte address |
| wdata | input | 32 | Write data or setup fields |
| rd_bank | input | $clog2(NB) | Bank tag of a read |
| rvalid | output | 1 | Read data valid, one cycle after the read |
| rdata | output | 32 | Read data |

## Verification
The bench uses the default parameters: four banks, a 1024-word RAM, control address 033Ch and buffer base 0400h. With a 1024-word RAM, a full fill and a pointer wrap at word 1023 fit easily into a short run. Four banks are enough for random interleaving to produce every pairing of a refill in flight with a read of the same bank or of a different bank. Both values of `bus16` are exercised in turn, so every phase of the half-word sequence meets setups and interleaving.

// File: rtl/bank_prefetch_rdport.sv
module bank_prefetch_rdport #(
  parameter int          NB        = 4,
  parameter int          RAM_AW    = 10,
  parameter logic [15:0] BUF_BASE  = 16'h0400,
  parameter logic [15:0] CTRL_ADDR = 16'h033C
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus16,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [15:0]           addr,
  input  logic [31:0]           wdata,
  input  logic [$clog2(NB)-1:0] rd_bank,
  output logic                  rvalid,
  output logic [31:0]           rdata
);
  localparam int BW    = $clog2(NB);
  localparam int DEPTH = 1 << RAM_AW;

  logic [31:0]                mem [DEPTH];
  logic [NB-1:0][RAM_AW-1:0]  ptr_q;
  logic [NB-1:0][31:0]        pf_q;
  logic [NB-1:0]              hi_q;
  logic [31:0]                ram_q;
  logic                       fill_v;
  logic [BW-1:0]              fill_b;

  wire in_buf = addr >= BUF_BASE;
  wire setup  = wr_en && addr == CTRL_ADDR;
  wire bwrite = wr_en && in_buf;
  wire rd     = rd_en && !wr_en;
  wire brd    = rd && in_buf;

  wire [BW-1:0]     sbank = wdata[16 +: BW];
  wire [13:0]       s_off = wdata[15:2] - BUF_BASE[15:2];
  wire [13:0]       w_off = addr[15:2] - BUF_BASE[15:2];
  wire [RAM_AW-1:0] sidx  = s_off[RAM_AW-1:0];
  wire [RAM_AW-1:0] widx  = w_off[RAM_AW-1:0];

  wire [31:0]       cur   = (fill_v && fill_b == rd_bank) ? ram_q : pf_q[rd_bank];
  wire              step  = brd && (!bus16 || hi_q[rd_bank]);
  wire [RAM_AW-1:0] nxt   = ptr_q[rd_bank] + 1'b1;
  wire [RAM_AW-1:0] raddr = setup ? sidx : nxt;

  logic unused_ok;
  assign unused_ok = ^{wdata[31:18], s_off[13:RAM_AW], w_off[13:RAM_AW]};

  always_ff @(posedge clk) begin
    if (bwrite) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_q  <= '0;
      fill_v <= 1'b0;
      fill_b <= '0;
      ptr_q  <= '0;
      pf_q   <= '0;
      hi_q   <= '0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      if (setup || step) ram_q <= mem[raddr];
      fill_v <= setup || step;
      fill_b <= setup ? sbank : rd_bank;
      if (fill_v) pf_q[fill_b] <= ram_q;
      if (setup) begin
        ptr_q[sbank] <= sidx;
        hi_q[sbank]  <= 1'b0;
      end
      if (brd && bus16) hi_q[rd_bank] <= !hi_q[rd_bank];
      if (step) ptr_q[rd_bank] <= nxt;
      rvalid <= rd;
      if (!brd)                 rdata <= '0;
      else if (!bus16)          rdata <= cur;
      else if (hi_q[rd_bank])   rdata <= {16'h0, cur[31:16]};
      else                      rdata <= {16'h0, cur[15:0]};
    end
  end
endmodule

// File: rtl/bank_prefetch_rdport_chk.sv
module bank_prefetch_rdport_chk #(
  parameter int          NB        = 4,
  parameter int          RAM_AW    = 10,
  parameter logic [15:0] BUF_BASE  = 16'h0400,
  parameter logic [15:0] CTRL_ADDR = 16'h033C
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus16,
  input logic                      wr_en,
  input logic                      rd_en,
  input logic [15:0]               addr,
  input logic [31:0]               wdata,
  input logic [$clog2(NB)-1:0]     rd_bank,
  input logic                      rvalid,
  input logic [31:0]               rdata,
  input logic [NB-1:0][RAM_AW-1:0] ptr_q
);
  localparam int BW = $clog2(NB);

  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> rvalid); // R4
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !wr_en) |=> !rvalid); // R4
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && bus16) |=> rdata[31:16] == 16'h0); // R7
  AST_REG_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr < BUF_BASE) |=> (rdata == 32'h0 && $stable(ptr_q))); // R8

  for (genvar k = 0; k < NB; k++) begin : g_bank
    AST_SETUP_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == CTRL_ADDR && wdata[16 +: BW] != BW'(k)) |=> $stable(ptr_q[k])); // R6
    AST_READ_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && rd_bank != BW'(k)) |=> $stable(ptr_q[k])); // R5
    AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && addr >= BUF_BASE && !bus16 && rd_bank == BW'(k))
      |=> ptr_q[k] == RAM_AW'($past(ptr_q[k]) + 1'b1)); // R4
  end
endmodule

bind bank_prefetch_rdport bank_prefetch_rdport_chk #(
  .NB(NB), .RAM_AW(RAM_AW), .BUF_BASE(BUF_BASE), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus16(bus16), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rd_bank(rd_bank), .rvalid(rvalid),
  .rdata(rdata), .ptr_q(ptr_q)
);

// File: tb/bank_prefetch_rdport_test.sv
`timescale 1ns/1ps
module bank_prefetch_rdport_test;
  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus16 = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  rd_bank = '0;
  logic        rvalid;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] mm [DEPTH];
  int          mptr [4];
  bit          mhi [4];

  always #5 clk = ~clk;

  bank_prefetch_rdport uut (
    .clk(clk), .rst_n(rst_n), .bus16(bus16), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_bank(rd_bank), .rvalid(rvalid), .rdata(rdata)
  );

  function automatic int widx(input logic [15:0] a);
    return (((int'(a) >> 2) - 256) & (DEPTH - 1));
  endfunction

  function automatic logic [31:0] expect_word(input int b, input bit b16);
    logic [31:0] w = mm[mptr[b]];
    if (!b16) return w;
    return mhi[b] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic buf_write(input logic [15:0] a, input logic [31:0] d);
    wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
    mm[widx(a)] = d;
    @(negedge clk);
    chk(rvalid == 1'b0, "R4 no valid after write", {31'h0, rvalid}, 32'h0);
  endtask

  task automatic setup(input int b, input logic [15:0] start);
    wr_en = 1'b1; rd_en = 1'b0; addr = 16'h033C;
    wdata = {14'($urandom), 2'(b), start};
    mptr[b] = widx(start);
    mhi[b] = 1'b0;
    @(negedge clk);
  endtask

  task automatic buf_read(input int b, input logic [15:0] a, input string tag);
    logic [31:0] exp = expect_word(b, bus16);
    wr_en = 1'b0; rd_en = 1'b1; addr = a; rd_bank = 2'(b);
    if (!bus16 || mhi[b]) begin
      mptr[b] = (mptr[b] + 1) & (DEPTH - 1);
      mhi[b] = 1'b0;
    end else mhi[b] = 1'b1;
    @(negedge clk);
    chk(rvalid == 1'b1 && rdata == exp, tag, rdata, exp);
  endtask

  task automatic reg_read(input logic [15:0] a);
    wr_en = 1'b0; rd_en = 1'b1; addr = a; rd_bank = 2'($urandom);
    @(negedge clk);
    chk(rvalid == 1'b1 && rdata == 32'h0, "R8 register read", rdata, 32'h0);
  endtask

  task automatic random_phase(input int n);
    for (int i = 0; i < n; i++) begin
      int r = $urandom_range(0, 99);
      int b = $urandom_range(0, 3);
      if (r < 10)
        setup(b, 16'h0400 + 16'(4 * $urandom_range(0, DEPTH - 1)) + 16'($urandom_range(0, 3)));
      else if (r < 88)
        buf_read(b, 16'h0400 + 16'($urandom_range(0, 16'hFBFF)), "R9 random stream");
      else if (r < 94)
        reg_read(16'($urandom_range(0, 16'h03FF)));
      else
        idle();
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !done) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 100000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    for (int b = 0; b < 4; b++) begin mptr[b] = 0; mhi[b] = 1'b0; end
    repeat (3) @(negedge clk);
    chk(rvalid == 1'b0 && rdata == 32'h0, "R1 reset state", rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rvalid == 1'b0 && rdata == 32'h0, "R1 after release", rdata, 32'h0);

    for (int i = 0; i < DEPTH; i++)
      buf_write(16'h0400 + 16'(4 * i) + 16'($urandom_range(0, 3)), $urandom);
    buf_write(16'h0417, 32'hCAFE_0005);
    buf_write(16'h1400, 32'hA11A_0000);

    setup(0, 16'h0416);
    buf_read(0, 16'hFFFF, "R3 first word right after setup");
    buf_read(0, 16'h0400, "R2 aligned neighbour");
    buf_read(0, 16'h8000, "R4 next word, address ignored");

    setup(3, 16'h13FC);
    buf_read(3, 16'h0500, "R10 last word");
    buf_read(3, 16'h0500, "R10 wrap to word 0");

    setup(1, 16'h0800);
    buf_read(0, 16'h0400, "R5 bank 0 after bank 1 setup");
    buf_read(1, 16'h0400, "R5 bank 1 interleaved");
    setup(2, 16'h0900);
    buf_read(1, 16'h0400, "R6 bank 1 untouched by bank 2 setup");
    reg_read(16'h0100);
    buf_read(0, 16'h0400, "R8 pointer unmoved by register read");
    idle();

    random_phase(3000);

    idle();
    bus16 = 1'b1;
    for (int b = 0; b < 4; b++) setup(b, 16'h0400 + 16'(4 * b));
    buf_read(0, 16'h0400, "R7 low half first");
    buf_read(0, 16'h0400, "R7 high half second");
    buf_read(1, 16'h0400, "R7 bank 1 low half");
    buf_read(0, 16'h0400, "R7 bank 0 advanced after high half");
    buf_read(1, 16'h0400, "R7 bank 1 high half after interleave");
    setup(2, 16'h13FC);
    buf_read(2, 16'h0400, "R10 low half last word");
    buf_read(2, 16'h0400, "R10 high half last word");
    buf_read(2, 16'h0400, "R10 wrap in 16-bit mode");

    random_phase(3000);

    idle();
    bus16 = 1'b0;
    for (int b = 0; b < 4; b++) setup(b, 16'h0400 + 16'(4 * $urandom_range(0, DEPTH - 1)));
    random_phase(1000);
    idle();
    chk(rvalid == 1'b0, "R4 idle after reads", {31'h0, rvalid}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule